// File: doc/BRIEF.md
# USB packet CRC engine

This block produces and checks the two cyclic redundancy codes that protect USB packets. A packet framer sends it one byte per clock. The framer raises a start strobe when a packet begins and an end strobe when the packet is over. A mode input picks the code to use.

In token mode the engine covers the 11-bit field that holds the device address and the endpoint number. It produces a 5-bit code. In data mode it covers the payload bytes that follow the DATA0 or DATA1 packet identifier. It produces a 16-bit code. The framer feeds neither the sync pattern nor the identifier byte to the engine.

For transmission the framer reads the complemented register on the CRC output. For reception the framer also feeds the received code through the engine. One cycle after the end strobe, a flag tells whether the register ended on the fixed residual that marks an intact packet.

The 16-bit code advances a whole byte per cycle through a 256-word table. The engine builds this table from the polynomial at elaboration. Both registers start at all ones and take bits least significant first. The 5-bit code uses x^5+x^2+1. The 16-bit code uses x^16+x^15+x^2+1.

Top module: `usb_crc_engine`

## Requirements
- R1: After reset `crc_o` is 0x0000 and `pass_o` is 0.
- R2: A start strobe reloads the register of the selected mode to all ones and clears `pass_o`. `mode_i` is sampled with the strobe: 0 selects token mode and 1 selects data mode. A byte that is valid in the same cycle is processed as the first byte of the new packet.
- R3: In data mode each valid byte updates the 16-bit register in one cycle. The update is the same as shifting the byte's 8 bits in least significant bit first, with the reflected polynomial 0xA001. From the next cycle `crc_o` shows the bitwise complement of the register.
- R4: A data packet with no payload bytes gives `crc_o` = 0x0000.
- R5: In token mode, byte 0 carries address[6:0] in bits 6:0 and endpoint[0] in bit 7, and byte 1 carries endpoint[3:1] in bits 2:0. After byte 1, `crc_o[4:0]` is the complement of the 5-bit register after those 11 bits, using reflected polynomial 0x14, and `crc_o[15:5]` is 0. Address 0 with endpoint 0 gives 0x02. Address 0x17 with endpoint 0 gives 0x11.
- R6: In token mode, bytes after the second have no effect on `crc_o` or on `pass_o`.
- R7: In data mode the received code follows the payload, low byte first. One cycle after `end_i`, `pass_o` is 1 exactly when the 16-bit register equals the residual left by an intact packet.
- R8: In token mode, bits 7:3 of byte 1 carry the received 5-bit code, least significant bit in bit 3. One cycle after `end_i`, `pass_o` is 1 exactly when both token bytes arrived and the 5-bit register, fed all 16 bits, equals the intact-packet residual.
- R9: A cycle with neither `valid_i` nor `start_i` leaves `crc_o` unchanged. `pass_o` changes only on a cycle after `start_i` or `end_i`.
- R10: A byte that is valid in the same cycle as `end_i` is counted in the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Packet start strobe; reloads the register |
| mode_i | input | 1 | 0 token code, 1 data code; sampled with start |
| valid_i | input | 1 | `data_i` holds a byte this cycle |
| data_i | input | 8 | Packet byte, bit 0 first on the wire |
| end_i | input | 1 | Packet end strobe; latches the check |
| crc_o | output | 16 | Complemented register, ready for transmission |
| pass_o | output | 1 | Received packet matched the residual |

## Verification
The case hardest to reach from the ports is the token second byte. Its low three bits extend the covered field, and its upper five bits must go on through the register for the residual. The bench sweeps all 2048 address and endpoint pairs, each once as a transmitted token and once as a received token. On some pairs it flips a code bit or adds a trailing byte. In data mode it uses every single-byte payload and several payload lengths, ends some packets with the end strobe on the last byte, and corrupts a payload byte to show that the flag drops.

// File: rtl/usb_crc_pkg.sv
package usb_crc_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CRC5_W  = 5;
  localparam int unsigned CRC16_W = 16;
  localparam int unsigned TBL_N   = 1 << BYTE_W;
  localparam int unsigned TOK_LO_BITS = 3;  // endpoint bits in token byte 1
  localparam logic [CRC5_W-1:0]  POLY5_REF  = 5'h14;
  localparam logic [CRC16_W-1:0] POLY16_REF = 16'hA001;

  typedef enum logic {MODE_TOKEN = 1'b0, MODE_DATA = 1'b1} crc_mode_e;

  function automatic logic [CRC5_W-1:0] crc5_feed(logic [CRC5_W-1:0] c,
                                                 logic [BYTE_W-1:0] v,
                                                 int unsigned n);
    logic [CRC5_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i < n) r = (r[0] ^ v[i]) ? ((r >> 1) ^ POLY5_REF) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [CRC16_W-1:0] crc16_bits(logic [CRC16_W-1:0] c,
                                                   logic [BYTE_W-1:0] v);
    logic [CRC16_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++)
      r = (r[0] ^ v[i]) ? ((r >> 1) ^ POLY16_REF) : (r >> 1);
    return r;
  endfunction

  // residual = register after an intact packet: complemented init fed back
  localparam logic [CRC16_W-1:0] RES16 = crc16_bits(crc16_bits('1, 8'h00), 8'h00);
  localparam logic [CRC5_W-1:0]  RES5  = crc5_feed('1, 8'h00, CRC5_W);
endpackage

// File: rtl/usb_crc16_lut.sv
module usb_crc16_lut
  import usb_crc_pkg::*;
(
  input  logic [BYTE_W-1:0]  idx_i,
  output logic [CRC16_W-1:0] word_o
);
  logic [CRC16_W-1:0] tbl [TBL_N];

  for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
    assign tbl[g] = crc16_bits(CRC16_W'(g), '0);
  end

  assign word_o = tbl[idx_i];
endmodule

// File: rtl/usb_crc16_unit.sv
module usb_crc16_unit
  import usb_crc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               en_i,
  input  logic [BYTE_W-1:0]  data_i,
  output logic [CRC16_W-1:0] crc_d_o,
  output logic [CRC16_W-1:0] crc_q_o
);
  logic [CRC16_W-1:0] base, tword;

  assign base = load_i ? '1 : crc_q_o;

  usb_crc16_lut u_lut (
    .idx_i  (base[BYTE_W-1:0] ^ data_i),
    .word_o (tword)
  );

  assign crc_d_o = en_i ? ((base >> BYTE_W) ^ tword) : base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q_o <= '1;
    else         crc_q_o <= crc_d_o;
  end
endmodule

// File: rtl/usb_crc5_unit.sv
module usb_crc5_unit
  import usb_crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC5_W-1:0] crc_q_o,
  output logic [CRC5_W-1:0] res_d_o,
  output logic              done_d_o
);
  localparam int unsigned CNT_W = 2;
  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_d;
  logic [CRC5_W-1:0] crc_base, crc_d, res_q, res_base;

  assign cnt_base = load_i ? '0 : cnt_q;
  assign crc_base = load_i ? '1 : crc_q_o;
  assign res_base = load_i ? '1 : res_q;

  always_comb begin
    cnt_d   = cnt_base;
    crc_d   = crc_base;
    res_d_o = res_base;
    if (en_i) begin
      unique case (cnt_base)
        2'd0: begin
          crc_d   = crc5_feed(crc_base, data_i, BYTE_W);
          res_d_o = crc_d;
          cnt_d   = 2'd1;
        end
        2'd1: begin
          crc_d   = crc5_feed(crc_base, data_i, TOK_LO_BITS);
          res_d_o = crc5_feed(crc_d, data_i >> TOK_LO_BITS, BYTE_W - TOK_LO_BITS);
          cnt_d   = 2'd2;
        end
        default: ;  // trailing bytes ignored
      endcase
    end
  end

  assign done_d_o = (cnt_d == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      crc_q_o <= '1;
      res_q   <= '1;
    end else begin
      cnt_q   <= cnt_d;
      crc_q_o <= crc_d;
      res_q   <= res_d_o;
    end
  end
endmodule

// File: rtl/usb_crc_engine.sv
module usb_crc_engine
  import usb_crc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic               valid_i,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic               end_i,
  output logic [CRC16_W-1:0] crc_o,
  output logic               pass_o
);
  crc_mode_e          mode_q, mode_eff;
  logic [CRC16_W-1:0] c16_d, c16_q;
  logic [CRC5_W-1:0]  c5_q, r5_d;
  logic               tok_done;

  assign mode_eff = start_i ? crc_mode_e'(mode_i) : mode_q;

  usb_crc16_unit u_c16 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_i),
    .en_i    (valid_i && mode_eff == MODE_DATA),
    .data_i  (data_i),
    .crc_d_o (c16_d),
    .crc_q_o (c16_q)
  );

  usb_crc5_unit u_c5 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .en_i     (valid_i && mode_eff == MODE_TOKEN),
    .data_i   (data_i),
    .crc_q_o  (c5_q),
    .res_d_o  (r5_d),
    .done_d_o (tok_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_DATA;
      pass_o <= 1'b0;
    end else begin
      mode_q <= mode_eff;
      if (end_i)
        pass_o <= (mode_eff == MODE_DATA) ? (c16_d == RES16)
                                          : (tok_done && r5_d == RES5);
      else if (start_i)
        pass_o <= 1'b0;
    end
  end

  assign crc_o = (mode_q == MODE_DATA) ? ~c16_q
                                       : {{(CRC16_W-CRC5_W){1'b0}}, ~c5_q};
endmodule

// File: rtl/usb_crc_engine_chk.sv
module usb_crc_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        valid_i,
  input logic        end_i,
  input logic [15:0] crc_o,
  input logic        pass_o
);
  a_r2_start_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_i |=> crc_o == 16'h0000);

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !end_i |=> !pass_o);

  a_r9_crc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !valid_i |=> $stable(crc_o));

  a_r9_pass_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !end_i |=> $stable(pass_o));
endmodule

bind usb_crc_engine usb_crc_engine_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .valid_i (valid_i),
  .end_i   (end_i),
  .crc_o   (crc_o),
  .pass_o  (pass_o)
);

// File: tb/tb_usb_crc_engine.sv
module tb_usb_crc_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, mode_i = 0, valid_i = 0, end_i = 0;
  logic [7:0]  data_i = '0;
  logic [15:0] crc_o;
  logic        pass_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_crc_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .valid_i(valid_i), .data_i(data_i), .end_i(end_i),
    .crc_o(crc_o), .pass_o(pass_o)
  );

  function automatic logic [4:0] m5(logic [4:0] c, int v, int n);
    for (int i = 0; i < n; i++)
      c = (c[0] != v[i]) ? ((c >> 1) ^ 5'b10100) : (c >> 1);
    return c;
  endfunction

  function automatic logic [15:0] m16(logic [15:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++)
      c = (c[0] != b[i]) ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pstart(bit m);
    start_i = 1; mode_i = m; valid_i = 0; end_i = 0;
    tick();
    start_i = 0;
  endtask

  task automatic put(logic [7:0] b, bit e);
    valid_i = 1; data_i = b; end_i = e;
    tick();
    valid_i = 0; end_i = 0;
  endtask

  task automatic pend();
    end_i = 1;
    tick();
    end_i = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pay [12];
    logic [15:0] m, tx;
    logic [4:0]  c5, t5;
    logic [15:0] hold;
    tick(); tick();
    rst_ni = 1;
    tick();
    chk(crc_o == 16'h0000, "R1", crc_o, 0);
    chk(pass_o == 1'b0, "R1", pass_o, 0);

    // R5 known token values
    pstart(0); put(8'h00, 0); put(8'h00, 0);
    chk(crc_o == 16'h0002, "R5", crc_o, 16'h0002);
    pstart(0); put(8'h17, 0); put(8'h00, 0);
    chk(crc_o == 16'h0011, "R5", crc_o, 16'h0011);

    // token sweep over every address/endpoint pair
    for (int a = 0; a < 128; a++) begin
      for (int e = 0; e < 16; e++) begin
        c5 = m5(5'h1F, a | (e << 7), 11);
        t5 = ~c5;
        pstart(0);
        put(8'(a | ((e & 1) << 7)), 0);
        put(8'(e >> 1), 0);
        chk(crc_o == {11'h0, t5}, "R5", crc_o, t5);
        pstart(0);
        put(8'(a | ((e & 1) << 7)), 0);
        if (e == 5) begin
          put(8'((e >> 1) | (t5 << 3)), 0);
          put(8'hA5, 0);  // trailing byte
          chk(crc_o == {11'h0, t5}, "R6", crc_o, t5);
          pend();
          chk(pass_o == 1'b1, "R6", pass_o, 1);
        end else if (e == 9) begin
          put(8'((e >> 1) | ((t5 ^ 5'(1 << (a % 5))) << 3)), 0);
          pend();
          chk(pass_o == 1'b0, "R8 corrupt", pass_o, 0);
        end else begin
          put(8'((e >> 1) | (t5 << 3)), 0);
          pend();
          chk(pass_o == 1'b1, "R8", pass_o, 1);
        end
      end
    end

    // R8 token with only one byte must fail
    pstart(0); put(8'h00, 0); pend();
    chk(pass_o == 1'b0, "R8 short", pass_o, 0);

    // R2 start clears pass; R9 idle holds
    pstart(1); put(8'h00, 0); put(8'h00, 0);
    chk(pass_o == 1'b0, "R2", pass_o, 0);
    chk(crc_o == ~m16(m16(16'hFFFF, 8'h00), 8'h00), "R3", crc_o, ~m16(m16(16'hFFFF, 8'h00), 8'h00));
    hold = crc_o;
    tick(); tick(); tick();
    chk(crc_o == hold, "R9", crc_o, hold);
    pend();
    hold = {15'h0, pass_o};
    tick(); tick();
    chk(pass_o == hold[0], "R9 pass hold", pass_o, hold[0]);
    pstart(1);
    chk(pass_o == 1'b0, "R2 clear", pass_o, 0);
    chk(crc_o == 16'h0000, "R2 reload", crc_o, 0);

    // R4 zero-length data packet
    pstart(1); pend();
    chk(crc_o == 16'h0000, "R4", crc_o, 0);
    pstart(1); put(8'h00, 0); put(8'h00, 0); pend();
    chk(pass_o == 1'b1, "R4 rx", pass_o, 1);

    // R3 every single-byte payload; start with byte in same cycle
    for (int b = 0; b < 256; b++) begin
      m = m16(16'hFFFF, 8'(b));
      start_i = 1; mode_i = 1; valid_i = 1; data_i = 8'(b);
      tick();
      start_i = 0; valid_i = 0;
      chk(crc_o == ~m, "R3 R2", crc_o, ~m);
      tx = ~m;
      put(tx[7:0], 0); put(tx[15:8], 1);
      chk(pass_o == 1'b1, "R7 R10", pass_o, 1);
    end

    // R7 R10 multi-byte payloads
    for (int len = 1; len <= 10; len++) begin
      for (int i = 0; i < len; i++) pay[i] = 8'((i * 37 + len * 11 + 3) & 8'hFF);
      m = 16'hFFFF;
      pstart(1);
      for (int i = 0; i < len; i++) begin
        put(pay[i], 0);
        m = m16(m, pay[i]);
        chk(crc_o == ~m, "R3", crc_o, ~m);
      end
      tx = ~m;
      put(tx[7:0], 0);
      if (len % 2 == 1) put(tx[15:8], 1);
      else begin put(tx[15:8], 0); pend(); end
      chk(pass_o == 1'b1, "R7", pass_o, 1);
      pstart(1);
      for (int i = 0; i < len; i++) put(pay[i] ^ ((i == len / 2) ? 8'h10 : 8'h00), 0);
      put(tx[7:0], 0); put(tx[15:8], 0); pend();
      chk(pass_o == 1'b0, "R7 corrupt", pass_o, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule